// File: doc/BRIEF.md
# Pixel Lane Formatter

This block sits between a rasterizer and a byte-addressable framebuffer RAM with a linear layout. Each clock it can take one pixel, given as integer x/y coordinates, a row stride, a frame base address, a 64-bit color word and a 2-bit storage-format code. It turns that pixel into one memory write: a strobe, a byte address, 32 bits of write data, a 4-bit byte-lane enable and a 32-bit bit-merge mask.

The RAM is expected to commit lane i only when the strobe and enable bit i are both high. The committed byte is (old & ~mask) | (data & mask). Because the mask has bit granularity, a 4-bit indexed pixel can be written into half of a byte without a read-modify-write cycle. All outputs are registered and appear one cycle after the pixel is presented.

Top module: `pix_lane_fmt`

## Requirements
- R1: A pixel presented with `pix_valid` high at a clock edge produces `wr_stb` high for exactly the following cycle. Back-to-back pixels give back-to-back strobes. A cycle without `pix_valid` gives `wr_stb` low in the next cycle.
- R2: The pixel offset is `pix_y * row_stride + pix_x`, computed without overflow.
- R3: With format code 2'b00 (32-bit), `wr_addr` = base + 4*offset, `wr_be` = 4'b1111 and `wr_mask` = 32'hFFFFFFFF.
- R4: With format code 2'b01 (16-bit), `wr_addr` = base + 2*offset, `wr_be` = 4'b0011 and `wr_mask` = 32'hFFFFFFFF. The address may be 2-byte but not 4-byte aligned and is not rounded.
- R5: With format code 2'b10 (8-bit indexed), `wr_addr` = base + offset, `wr_be` = 4'b0001 and `wr_mask` = 32'hFFFFFFFF.
- R6: With format code 2'b11 (4-bit indexed), `wr_addr` = base + (offset >> 1) and `wr_be` = 4'b0001. `wr_mask` is 32'h0000000F for an even offset and 32'h000000F0 for an odd one. `wr_data` is {color[31:8], color[3:0], color[3:0]}.
- R7: For format codes 2'b00, 2'b01 and 2'b10, `wr_data` equals color bits [31:0]. Color bits [63:32] never reach any output.
- R8: A cycle without `pix_valid` leaves `wr_addr`, `wr_data`, `wr_be` and `wr_mask` unchanged.
- R9: While `rst_n` is low at a clock edge, `wr_stb`, `wr_addr`, `wr_data`, `wr_be` and `wr_mask` are cleared to zero in the next cycle, even if `pix_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_valid | input | 1 | Pixel present this cycle |
| fb_base | input | ADDR_W | Frame base byte address |
| row_stride | input | COORD_W | Pixels per row |
| pix_x | input | COORD_W | Pixel column |
| pix_y | input | COORD_W | Pixel row |
| pix_color | input | 64 | Color word; only bits [31:0] are used |
| pix_fmt | input | 2 | Storage format: 00 32-bit, 01 16-bit, 10 8-bit, 11 4-bit |
| wr_stb | output | 1 | Write strobe, one cycle per pixel |
| wr_addr | output | ADDR_W | Byte address of lane 0 |
| wr_data | output | 32 | Write data, lane i in bits [8i+7:8i] |
| wr_be | output | 4 | Byte-lane enables |
| wr_mask | output | 32 | Bit-merge mask |

## Verification
Every output register is written in the same cycle as the strobe. A wrong shift choice, a wrong lane enable or a wrong nibble selection therefore shows at the ports on the first pixel of the affected format, one cycle after it is presented. A hold fault appears as changed outputs in the first idle cycle after a write. A reset fault appears in the first cycle after the reset edge. The bench covers both nibble parities at the same byte address and an odd 16-bit slot, which separates the parity-based and shift-based failures.

// File: rtl/pix_lane_fmt.sv
module pix_lane_fmt #(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_valid,
  input  logic [ADDR_W-1:0]    fb_base,
  input  logic [COORD_W-1:0]   row_stride,
  input  logic [COORD_W-1:0]   pix_x,
  input  logic [COORD_W-1:0]   pix_y,
  input  logic [63:0]          pix_color,
  input  logic [1:0]           pix_fmt,
  output logic                 wr_stb,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [31:0]          wr_data,
  output logic [3:0]           wr_be,
  output logic [31:0]          wr_mask
);
  localparam int OFF_W = 2*COORD_W + 1;
  localparam logic [1:0] FMT_32 = 2'b00;
  localparam logic [1:0] FMT_16 = 2'b01;
  localparam logic [1:0] FMT_8  = 2'b10;
  localparam logic [1:0] FMT_4  = 2'b11;

  logic [2*COORD_W-1:0] prod;
  logic [OFF_W-1:0]     off;
  logic [ADDR_W-1:0]    off_a, byte_off, addr_n;
  logic [31:0]          data_n, mask_n;
  logic [3:0]           be_n;

  assign prod  = {{COORD_W{1'b0}}, pix_y} * {{COORD_W{1'b0}}, row_stride};
  assign off   = {1'b0, prod} + {{(COORD_W+1){1'b0}}, pix_x};
  assign off_a = ADDR_W'(off);

  always_comb begin
    byte_off = off_a;
    be_n     = 4'b0001;
    mask_n   = 32'hFFFF_FFFF;
    data_n   = pix_color[31:0];
    case (pix_fmt)
      FMT_32: begin byte_off = off_a << 2; be_n = 4'b1111; end
      FMT_16: begin byte_off = off_a << 1; be_n = 4'b0011; end
      FMT_8:  begin byte_off = off_a; end
      FMT_4: begin
        byte_off = off_a >> 1;
        mask_n   = off[0] ? 32'h0000_00F0 : 32'h0000_000F;
        data_n   = {pix_color[31:8], pix_color[3:0], pix_color[3:0]};
      end
      default: ;
    endcase
  end

  assign addr_n = fb_base + byte_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_be   <= '0;
      wr_mask <= '0;
    end else begin
      wr_stb <= pix_valid;
      if (pix_valid) begin
        wr_addr <= addr_n;
        wr_data <= data_n;
        wr_be   <= be_n;
        wr_mask <= mask_n;
      end
    end
  end

  AST_STB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> wr_stb); // R1
  AST_STB_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !wr_stb); // R1
  AST_WORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_fmt == 2'b00 |=> wr_be == 4'b1111 && wr_mask == 32'hFFFF_FFFF); // R3
  AST_HALF_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_fmt == 2'b01 |=> wr_be == 4'b0011 && wr_addr[0] == $past(fb_base[0])); // R4
  AST_NIBBLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && wr_mask != 32'hFFFF_FFFF |-> wr_be == 4'b0001 &&
      (wr_mask == 32'h0000_000F || wr_mask == 32'h0000_00F0)); // R6
  AST_LOW_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_fmt != 2'b11 |=> wr_data == $past(pix_color[31:0])); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(wr_addr) && $stable(wr_be) && $stable(wr_mask) && $stable(wr_data)); // R8
endmodule

// File: tb/pix_lane_fmt_test.sv
`timescale 1ns/1ps
module pix_lane_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [31:0] fb_base = '0;
  logic [11:0] row_stride = '0, pix_x = '0, pix_y = '0;
  logic [63:0] pix_color = '0;
  logic [1:0]  pix_fmt = '0;
  logic        wr_stb;
  logic [31:0] wr_addr, wr_data, wr_mask;
  logic [3:0]  wr_be;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pix_lane_fmt uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .fb_base(fb_base),
    .row_stride(row_stride), .pix_x(pix_x), .pix_y(pix_y),
    .pix_color(pix_color), .pix_fmt(pix_fmt), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_mask(wr_mask));

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [1:0] f, input logic [31:0] b,
      input int s, input int x, input int y);
    longint off = longint'(y) * s + x;
    case (f)
      2'b00: return b + 32'(off * 4);
      2'b01: return b + 32'(off * 2);
      2'b10: return b + 32'(off);
      default: return b + 32'(off / 2);
    endcase
  endfunction

  task automatic present(input logic [1:0] f, input logic [31:0] b, input int s,
                         input int x, input int y, input logic [63:0] c);
    @(negedge clk);
    pix_fmt = f; fb_base = b; row_stride = 12'(s); pix_x = 12'(x); pix_y = 12'(y);
    pix_color = c; pix_valid = 1'b1;
    @(posedge clk); #1;
    pix_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pix_valid = 1'b1; pix_color = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "stb", 64'(wr_stb), 64'd0);
    chk("R9", "addr", 64'(wr_addr), 64'd0);
    chk("R9", "data", 64'(wr_data), 64'd0);
    chk("R9", "be", 64'(wr_be), 64'd0);
    chk("R9", "mask", 64'(wr_mask), 64'd0);
    @(negedge clk); pix_valid = 1'b0; rst_n = 1'b1;
  endtask

  task automatic t_fmt32();
    present(2'b00, 32'h0000_1000, 640, 3, 2, 64'h3F80_0000_AABB_CCDD);
    chk("R1", "stb", 64'(wr_stb), 64'd1);
    chk("R2 R3", "addr", 64'(wr_addr), 64'(exp_addr(2'b00, 32'h1000, 640, 3, 2)));
    chk("R3", "be", 64'(wr_be), 64'hF);
    chk("R3", "mask", 64'(wr_mask), 64'hFFFF_FFFF);
    chk("R7", "data", 64'(wr_data), 64'hAABB_CCDD);
    @(posedge clk); #1;
    chk("R1", "stb drop", 64'(wr_stb), 64'd0);
  endtask

  task automatic t_fmt16();
    present(2'b01, 32'h0002_0000, 100, 7, 5, 64'h1234_5678_0000_BEEF);
    chk("R4", "addr", 64'(wr_addr), 64'(exp_addr(2'b01, 32'h20000, 100, 7, 5)));
    chk("R4", "addr odd slot", 64'(wr_addr[1:0]), 64'd2);
    chk("R4", "be", 64'(wr_be), 64'h3);
    chk("R4", "mask", 64'(wr_mask), 64'hFFFF_FFFF);
    chk("R7", "data", 64'(wr_data), 64'h0000_BEEF);
  endtask

  task automatic t_fmt8();
    present(2'b10, 32'h0000_0400, 4095, 4095, 4095, 64'hDEAD_BEEF_0000_0077);
    chk("R2 R5", "addr max coords", 64'(wr_addr), 64'(exp_addr(2'b10, 32'h400, 4095, 4095, 4095)));
    chk("R5", "be", 64'(wr_be), 64'h1);
    chk("R5", "mask", 64'(wr_mask), 64'hFFFF_FFFF);
    chk("R7", "data", 64'(wr_data), 64'h0000_0077);
  endtask

  task automatic t_fmt4();
    present(2'b11, 32'h0000_8000, 16, 4, 1, 64'hFFFF_FFFF_0000_000A);
    chk("R6", "even addr", 64'(wr_addr), 64'(exp_addr(2'b11, 32'h8000, 16, 4, 1)));
    chk("R6", "even be", 64'(wr_be), 64'h1);
    chk("R6", "even mask", 64'(wr_mask), 64'h0000_000F);
    chk("R6", "even data", 64'(wr_data), 64'h0000_00AA);
    present(2'b11, 32'h0000_8000, 16, 5, 1, 64'h0000_0000_1234_5663);
    chk("R6", "odd addr", 64'(wr_addr), 64'(exp_addr(2'b11, 32'h8000, 16, 5, 1)));
    chk("R6", "odd mask", 64'(wr_mask), 64'h0000_00F0);
    chk("R6", "odd data", 64'(wr_data), 64'h1234_5633);
  endtask

  task automatic t_hold();
    present(2'b00, 32'h0000_0100, 8, 1, 1, 64'h0000_0000_0102_0304);
    @(negedge clk);
    pix_fmt = 2'b11; fb_base = 32'hFFFF_0000; pix_x = 12'd9; pix_color = '1;
    @(posedge clk); #1;
    chk("R8", "addr", 64'(wr_addr), 64'(exp_addr(2'b00, 32'h100, 8, 1, 1)));
    chk("R8", "data", 64'(wr_data), 64'h0102_0304);
    chk("R8", "be", 64'(wr_be), 64'hF);
    chk("R8", "mask", 64'(wr_mask), 64'hFFFF_FFFF);
    chk("R1", "idle stb", 64'(wr_stb), 64'd0);
  endtask

  task automatic t_burst();
    @(negedge clk);
    pix_fmt = 2'b10; fb_base = '0; row_stride = 12'd10; pix_y = 12'd0;
    pix_color = 64'h11; pix_x = 12'd0; pix_valid = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(posedge clk); #1;
      chk("R1", "burst stb", 64'(wr_stb), 64'd1);
      chk("R5", "burst addr", 64'(wr_addr), 64'(i - 1));
      pix_x = 12'(i);
    end
    pix_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1", "burst end", 64'(wr_stb), 64'd0);
  endtask

  task automatic t_reset_mid();
    present(2'b00, 32'h0000_0200, 4, 1, 0, 64'h55);
    @(negedge clk); rst_n = 1'b0; pix_valid = 1'b1;
    @(posedge clk); #1;
    chk("R9", "mid stb", 64'(wr_stb), 64'd0);
    chk("R9", "mid addr", 64'(wr_addr), 64'd0);
    chk("R9", "mid mask", 64'(wr_mask), 64'd0);
    @(negedge clk); rst_n = 1'b1; pix_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_fmt32();
    t_fmt16();
    t_fmt8();
    t_fmt4();
    t_hold();
    t_burst();
    t_reset_mid();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule